// File: doc/BRIEF.md
# ADC Window Watchdog Comparator

This block sits beside a converter's result path and watches each finished 12-bit conversion for values outside a programmable window. It compares the raw, unaligned result against an upper and a lower bound. When a monitored result falls outside the window, it sets a sticky status flag. The flag can also drive an interrupt line.

Monitoring is gated per conversion group (regular and injected). An optional filter restricts the check to one channel number, and that filter applies to both groups. Software programs the block through a small write-only register port. It clears the flag by writing a one to a dedicated clear location.

Register map (address on `cfg_addr`):

| Address | Fields |
|---|---|
| 0 (control) | bit 0 enables the regular group, bit 1 enables the injected group, bit 2 selects single-channel mode, bit 3 enables the interrupt, bits 8:4 hold the channel |
| 1 | Upper bound, bits 11:0 |
| 2 | Lower bound, bits 11:0 |
| 3 | Clear; bit 0 written as 1 clears the flag |

Top module: `adc_window_watch`

## Requirements
- R1: After reset the flag and the interrupt are low, the upper bound is 0xFFF and the lower bound is 0, so no result value can set the flag until the bounds are changed.
- R2: A result is out of window only when it is strictly above the upper bound or strictly below the lower bound; a value equal to either bound is inside.
- R3: A result tagged regular (`res_inj`=0) is checked only when control bit 0 is set. A result tagged injected (`res_inj`=1) is checked only when control bit 1 is set. With both bits clear, no result sets the flag.
- R4: With control bit 2 clear, results from every channel are checked. With it set, only results whose `res_chan` equals the stored channel are checked, and the same channel applies to both groups.
- R5: A control write stores the channel from bits 8:4 only if the value in bits 15:4 is 17 or less; otherwise the stored channel becomes 0.
- R6: A write to either bound keeps bits 11:0 and discards bits 15:12.
- R7: The flag rises on the clock edge that samples a valid, checked, out-of-window result. It stays set until a write to address 3 with bit 0 at 1. A write with bit 0 at 0 leaves it set. A new event in the same cycle as a clear leaves it set.
- R8: `wd_irq` is high exactly when the flag is set and control bit 3 is set.
- R9: A configuration write takes effect from the following cycle. A result presented in the same cycle as the write is judged against the previous settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 16 | Register write data |
| res_valid | input | 1 | Conversion result strobe |
| res_data | input | 12 | Raw unaligned result |
| res_chan | input | 5 | Channel number of the result |
| res_inj | input | 1 | Group tag: 1 injected, 0 regular |
| wd_flag | output | 1 | Sticky out-of-window flag |
| wd_irq | output | 1 | Interrupt request |

## Verification
Any corrupted configuration field or flag bit shows up at `wd_flag` one clock after the next stimulus that depends on it. This applies to a wrong bound, a wrong group gate, a wrong stored channel, or a flag that is lost or spurious. A bad interrupt-enable bit shows up on `wd_irq` in the same cycle the flag is high. A behavioural model predicts both outputs every clock, so a divergence is caught on the first cycle it appears. Directed sequences place results exactly on the bounds, one step beyond them, on filtered and unfiltered channels, and in the same cycle as clears and configuration writes, so that each wrong state becomes visible.

// File: rtl/adc_wd_pkg.sv
package adc_wd_pkg;
    localparam int DATA_W   = 12;
    localparam int CHAN_W   = 5;
    localparam int ADDR_W   = 2;
    localparam int WDATA_W  = 16;
    localparam int MAX_CHAN = 17;

    localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] A_UPPER = 2'd1;
    localparam logic [ADDR_W-1:0] A_LOWER = 2'd2;
    localparam logic [ADDR_W-1:0] A_CLEAR = 2'd3;

    // control field positions
    localparam int B_REG_EN = 0;
    localparam int B_INJ_EN = 1;
    localparam int B_SINGLE = 2;
    localparam int B_IRQ_EN = 3;
    localparam int B_CHAN   = 4;

    typedef struct packed {
        logic              reg_en;
        logic              inj_en;
        logic              single;
        logic              irq_en;
        logic [CHAN_W-1:0] chan;
        logic [DATA_W-1:0] upper;
        logic [DATA_W-1:0] lower;
    } wd_cfg_t;
endpackage

// File: rtl/adc_wd_cfg.sv
module adc_wd_cfg
    import adc_wd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [WDATA_W-1:0] wdata,
    output wd_cfg_t            cfg,
    output logic               clr
);
    localparam int HI_W = WDATA_W - B_CHAN;

    wd_cfg_t cfg_d, cfg_q;
    logic [HI_W-1:0] chan_raw;

    assign chan_raw = wdata[WDATA_W-1:B_CHAN];

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            unique case (addr)
                A_CTRL: begin
                    cfg_d.reg_en = wdata[B_REG_EN];
                    cfg_d.inj_en = wdata[B_INJ_EN];
                    cfg_d.single = wdata[B_SINGLE];
                    cfg_d.irq_en = wdata[B_IRQ_EN];
                    cfg_d.chan   = (chan_raw > HI_W'(MAX_CHAN)) ? '0
                                 : chan_raw[CHAN_W-1:0];
                end
                A_UPPER: cfg_d.upper = wdata[DATA_W-1:0];
                A_LOWER: cfg_d.lower = wdata[DATA_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q       <= '0;
            cfg_q.upper <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;
    assign clr = we && (addr == A_CLEAR) && wdata[0];
endmodule

// File: rtl/adc_wd_cmp.sv
module adc_wd_cmp
    import adc_wd_pkg::*;
(
    input  wd_cfg_t           cfg,
    input  logic              valid,
    input  logic [DATA_W-1:0] data,
    input  logic [CHAN_W-1:0] chan,
    input  logic              inj,
    output logic              hit
);
    logic group_ok, chan_ok, outside;

    always_comb begin
        group_ok = inj ? cfg.inj_en : cfg.reg_en;
        chan_ok  = !cfg.single || (chan == cfg.chan);
        outside  = (data > cfg.upper) || (data < cfg.lower);
        hit      = valid && group_ok && chan_ok && outside;
    end
endmodule

// File: rtl/adc_window_watch.sv
module adc_window_watch
    import adc_wd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [WDATA_W-1:0] cfg_wdata,
    input  logic               res_valid,
    input  logic [DATA_W-1:0]  res_data,
    input  logic [CHAN_W-1:0]  res_chan,
    input  logic               res_inj,
    output logic               wd_flag,
    output logic               wd_irq
);
    wd_cfg_t cfg_w;
    logic    clr_w, hit_w;
    logic    flag_d, flag_q;

    adc_wd_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .cfg(cfg_w), .clr(clr_w)
    );

    adc_wd_cmp u_cmp (
        .cfg(cfg_w), .valid(res_valid), .data(res_data),
        .chan(res_chan), .inj(res_inj), .hit(hit_w)
    );

    // a fresh event outranks a clear in the same cycle
    always_comb begin
        flag_d = flag_q;
        if (clr_w) flag_d = 1'b0;
        if (hit_w) flag_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign wd_flag = flag_q;
    assign wd_irq  = flag_q && cfg_w.irq_en;
endmodule

// File: rtl/adc_wd_chk.sv
module adc_wd_chk
    import adc_wd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              hit,
    input logic              clr,
    input logic              wd_flag,
    input logic              wd_irq,
    input logic [CHAN_W-1:0] chan_q
);
    a_r7_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> wd_flag);
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_flag && !clr) |=> wd_flag);
    a_r7_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_flag) |-> $past(hit));
    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wd_irq |-> wd_flag);
    a_r5_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
        chan_q <= CHAN_W'(MAX_CHAN));
endmodule

bind adc_window_watch adc_wd_chk u_chk (
    .clk(clk), .rst_n(rst_n), .hit(hit_w), .clr(clr_w),
    .wd_flag(wd_flag), .wd_irq(wd_irq), .chan_q(cfg_w.chan)
);

// File: tb/sim_adc_window_watch.sv
`timescale 1ns/1ps
module sim_adc_window_watch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        vld = 1'b0;
    logic [11:0] data = '0;
    logic [4:0]  ch = '0;
    logic        inj = 1'b0;
    logic        flag, irq;
    int n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    adc_window_watch u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(we), .cfg_addr(addr),
        .cfg_wdata(wdata), .res_valid(vld), .res_data(data),
        .res_chan(ch), .res_inj(inj), .wd_flag(flag), .wd_irq(irq)
    );

    // behavioural reference
    int  m_up = 4095, m_lo = 0, m_ch = 0;
    bit  m_re = 0, m_ie = 0, m_sg = 0, m_irqen = 0, m_flag = 0;
    always @(posedge clk) begin
        bit ev, cl;
        if (!rst_n) begin
            m_up = 4095; m_lo = 0; m_ch = 0;
            m_re = 0; m_ie = 0; m_sg = 0; m_irqen = 0; m_flag = 0;
        end else begin
            ev = vld && (inj ? m_ie : m_re) && (!m_sg || int'(ch) == m_ch)
                 && (int'(data) > m_up || int'(data) < m_lo);
            cl = we && addr == 3 && wdata[0];
            if (ev) m_flag = 1; else if (cl) m_flag = 0;
            if (we) case (addr)
                0: begin
                    m_re = wdata[0]; m_ie = wdata[1]; m_sg = wdata[2];
                    m_irqen = wdata[3];
                    m_ch = (int'(wdata[15:4]) > 17) ? 0 : int'(wdata[15:4]);
                end
                1: m_up = int'(wdata[11:0]);
                2: m_lo = int'(wdata[11:0]);
                default: ;
            endcase
        end
    end

    always @(negedge clk) if (rst_n) begin
        n_run++;
        if (flag !== m_flag || irq !== (m_flag && m_irqen)) begin
            n_fail++;
            $display("FAIL R7/R8 model: flag=%0b irq=%0b expected %0b %0b",
                     flag, irq, m_flag, m_flag && m_irqen);
        end
    end

    task automatic chk(string tag, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic cyc(bit w, logic [1:0] a, logic [15:0] d,
                       bit v, logic [11:0] x, logic [4:0] c, bit j);
        we = w; addr = a; wdata = d; vld = v; data = x; ch = c; inj = j;
        @(negedge clk);
        we = 0; vld = 0;
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        cyc(1, a, d, 0, 0, 0, 0);
    endtask

    task automatic res(logic [11:0] x, logic [4:0] c, bit j);
        cyc(0, 0, 0, 1, x, c, j);
    endtask

    task automatic clear();
        wr(3, 16'h1);
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1 reset flag", flag, 0);
        chk("R1 reset irq", irq, 0);
        wr(0, 16'h0003);
        res(12'hFFF, 3, 0); res(12'h000, 3, 1);
        chk("R1 extremes never fire", flag, 0);

        wr(1, 16'h0800); wr(2, 16'h0100);
        res(12'h800, 0, 0); res(12'h100, 0, 0);
        chk("R2 equal to bounds inside", flag, 0);
        res(12'h801, 0, 0);
        chk("R2 above upper fires", flag, 1);
        chk("R8 irq off while disabled", irq, 0);
        wr(3, 16'h0000);
        chk("R7 write zero keeps flag", flag, 1);
        clear();
        chk("R7 clear", flag, 0);
        res(12'h0FF, 9, 0);
        chk("R2 below lower fires", flag, 1);
        clear();

        wr(0, 16'h0001);
        res(12'hF00, 2, 1);
        chk("R3 injected gated off", flag, 0);
        wr(0, 16'h0002);
        res(12'hF00, 2, 0);
        chk("R3 regular gated off", flag, 0);
        res(12'hF00, 2, 1);
        chk("R3 injected enabled", flag, 1);
        clear();
        wr(0, 16'h0000);
        res(12'hF00, 2, 1); res(12'h000, 2, 0);
        chk("R3 none enabled", flag, 0);

        wr(0, 16'h0057);
        res(12'hF00, 4, 0);
        chk("R4 other channel filtered", flag, 0);
        res(12'hF00, 5, 1);
        chk("R4 selected channel injected", flag, 1);
        clear();
        res(12'h000, 5, 0);
        chk("R4 selected channel regular", flag, 1);
        clear();
        wr(0, 16'h0053);
        res(12'hF00, 4, 0);
        chk("R4 all channels when clear", flag, 1);
        clear();

        wr(0, 16'h0147);
        res(12'hF00, 5, 0);
        chk("R5 out-of-range channel not 5", flag, 0);
        res(12'hF00, 0, 0);
        chk("R5 out-of-range becomes 0", flag, 1);
        clear();
        wr(0, 16'h0117);
        res(12'hF00, 17, 0);
        chk("R5 channel 17 accepted", flag, 1);
        clear();
        wr(0, 16'h1057);
        res(12'hF00, 5, 0);
        chk("R5 high bits make range fail", flag, 0);

        wr(0, 16'h0003);
        wr(1, 16'hF005); wr(2, 16'hF000);
        res(12'h005, 1, 0);
        chk("R6 upper high bits dropped", flag, 0);
        res(12'h000, 1, 0);
        chk("R6 lower high bits dropped", flag, 0);
        res(12'h006, 1, 0);
        chk("R6 truncated upper fires", flag, 1);

        wr(0, 16'h000B);
        chk("R8 irq follows flag", irq, 1);
        clear();
        chk("R8 irq drops with flag", irq, 0);

        cyc(1, 3, 16'h1, 1, 12'h900, 0, 0);
        chk("R7 event beats clear", flag, 1);
        clear();

        cyc(1, 0, 16'h0000, 1, 12'h900, 0, 0);
        chk("R9 old config judges result", flag, 1);
        clear();
        res(12'h900, 0, 0);
        chk("R9 new config in force", flag, 0);
        cyc(1, 1, 16'h0FFF, 0, 0, 0, 0);
        wr(0, 16'h0001);
        cyc(1, 1, 16'h0000, 1, 12'h001, 0, 0);
        chk("R9 upper change not yet applied", flag, 0);

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule